// File: doc/BRIEF.md
# Configurable Per-Pin I/O Register Cell

This block is the logic layer between the core fabric and a row of pad buffers. Each of its `LANES` lanes carries one pin. A static configuration word picks the pin's role: off, input only, output only, bidirectional, or forwarding of the output clock to the pad. All lanes share that word. Within those roles, the configuration also sets each path as follows:

- whether the path is combinational or registered;
- which clock edge each register triggers on;
- whether the input is captured at double data rate;
- whether the output is launched at double data rate;
- whether the launched data is inverted.

The input registers run on `clk_in`. The output and output-enable registers run on `clk_out`. Each clock domain releases its registers through its own two-stage reset synchroniser. An alternate-function input path returns the pad value to the core combinationally, whatever the register settings are. The pad side is modelled as a data bit, a drive-enable bit and a pull indication. The pull indication asks for a weak pull-up, or a weak pull-down when configured, while the pin is unused.

The configuration inputs are meant to be held stable and changed only while `rst_n` is low.

Top module: `pin_io_cell`

## Requirements
- R1: Mode codes on `cfg_mode` are 0 = off, 1 = input, 2 = output, 3 = bidirectional, 4 = clock-out. Codes 5 to 7 behave as off. In off, `pad_oe`, `pad_out`, `core_in_hi`, `core_in_lo` and `core_alt` are all zero. Also in off, `pad_pull_en` is 1 and `pad_pull_up` is the inverse of `cfg_pull_dn`. In every other mode both pull outputs are 0.
- R2: In input or bidirectional mode with `cfg_in_reg`=0, `core_in_hi` equals `pad_in` combinationally and `core_in_lo` is 0. Outside those two modes, `core_in_hi` and `core_in_lo` are 0.
- R3: With `cfg_in_reg`=1 and `cfg_in_ddr`=0, `core_in_hi` shows the `pad_in` value sampled at the most recent `clk_in` edge. That edge is rising when `cfg_in_neg`=0 and falling when `cfg_in_neg`=1.
- R4: With `cfg_in_reg`=1 and `cfg_in_ddr`=1, `core_in_hi` holds the last rising-edge sample of `pad_in` and `core_in_lo` holds the last falling-edge sample. `cfg_in_neg` is ignored in this setting.
- R5: In input and bidirectional modes, `core_alt` equals `pad_in` combinationally, independent of `cfg_in_reg` and `cfg_in_ddr`.
- R6: In output mode, `pad_oe` is all ones and `core_oe` is ignored. With `cfg_out_reg`=0, `pad_out` equals `core_out_hi` combinationally.
- R7: With `cfg_out_reg`=1 and `cfg_out_ddr`=0, `pad_out` shows `core_out_hi` as captured at the last `clk_out` edge. That edge is rising when `cfg_out_neg`=0 and falling when `cfg_out_neg`=1.
- R8: With `cfg_out_reg`=1 and `cfg_out_ddr`=1, both `core_out_hi` and `core_out_lo` are captured at each rising `clk_out` edge. `pad_out` then shows the `core_out_hi` bit while `clk_out` is high, and the `core_out_lo` bit while `clk_out` is low.
- R9: When `cfg_out_inv`=1, the data that output or bidirectional mode drives onto `pad_out` is inverted, for both the direct and the registered setting.
- R10: In bidirectional mode, `pad_oe` follows `core_oe` through the same direct or registered choice as the data. In DDR it follows the rising edge. While `pad_oe` is 0, `pad_out` is 0 and the input path keeps sampling `pad_in`.
- R11: In clock-out mode, `pad_oe` is all ones and every `pad_out` bit equals `clk_out`.
- R12: Asserting `rst_n` clears every register at once. After release, a domain's registers start capturing at the third rising edge of their own clock. Until then, registered outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock of the input capture registers |
| clk_out | input | 1 | Clock of the output and enable registers; forwarded in clock-out mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Pin role code (see R1) |
| cfg_in_reg | input | 1 | Register the input path |
| cfg_in_neg | input | 1 | Input register triggers on the falling edge |
| cfg_in_ddr | input | 1 | Double-rate input capture |
| cfg_out_reg | input | 1 | Register the output and enable paths |
| cfg_out_neg | input | 1 | Output registers trigger on the falling edge |
| cfg_out_ddr | input | 1 | Double-rate output launch |
| cfg_out_inv | input | 1 | Invert the driven data |
| cfg_pull_dn | input | 1 | Request pull-down instead of pull-up when unused |
| core_out_hi | input | LANES | Core data to the pad (high-phase bit in DDR) |
| core_out_lo | input | LANES | Low-phase core data bit in DDR |
| core_oe | input | LANES | Core drive enable, active high |
| pad_in | input | LANES | Value seen at the pad |
| core_in_hi | output | LANES | Captured or direct pad data (rising sample in DDR) |
| core_in_lo | output | LANES | Falling-edge pad sample in DDR |
| core_alt | output | LANES | Unregistered alternate-function input |
| pad_out | output | LANES | Data presented to the pad buffer |
| pad_oe | output | LANES | Pad buffer drive enable |
| pad_pull_en | output | 1 | Weak pull requested |
| pad_pull_up | output | 1 | Pull direction is up |

## Verification
Assertions watch the register hand-offs every cycle. Each enabled input register must hold the pad value from the previous edge of the chosen polarity. Each output and enable register must hold the core value from its previous edge. The DDR low-phase register must hold the bit captured at the preceding rising edge. In off mode, no enable and no core-side data may appear.

Other behaviours depend on the whole configuration and on the phase of two unrelated clocks, so only the bench scenarios can show them. These are:
- the high and low phase multiplexing of DDR output seen at the pad;
- inversion applied on the direct path;
- pull direction selection;
- clock forwarding;
- the three-edge delay before capture resumes after reset.

// File: rtl/pin_io_pkg.sv
`timescale 1ns/1ps
package pin_io_pkg;

  typedef enum logic [2:0] {
    PM_OFF    = 3'd0,
    PM_IN     = 3'd1,
    PM_OUT    = 3'd2,
    PM_BIDIR  = 3'd3,
    PM_CLKOUT = 3'd4
  } pin_mode_e;

  // Per-direction register options
  typedef struct packed {
    logic reg_en;
    logic neg_edge;
    logic ddr;
  } path_cfg_t;

endpackage

// File: rtl/pin_rst_sync.sv
`timescale 1ns/1ps
module pin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pin_in_path.sv
`timescale 1ns/1ps
module pin_in_path
  import pin_io_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      path_en,
  input  path_cfg_t cfg,
  input  logic      pad_i,
  output logic      data_hi,
  output logic      data_lo,
  output logic      alt
);

  logic rise_q, rise_d;
  logic fall_q, fall_d;

  // next-state with explicit clock enable
  always_comb begin
    rise_d = path_en ? pad_i : rise_q;
    fall_d = path_en ? pad_i : fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= fall_d;
  end

  always_comb begin
    data_hi = 1'b0;
    data_lo = 1'b0;
    if (path_en) begin
      if (!cfg.reg_en) begin
        data_hi = pad_i;
      end else if (cfg.ddr) begin
        data_hi = rise_q;
        data_lo = fall_q;
      end else begin
        data_hi = cfg.neg_edge ? fall_q : rise_q;
      end
    end
  end

  // alternate function input never passes through a register
  assign alt = path_en & pad_i;

  // R3: rising-edge capture holds the previous edge's pad value
  a_r3_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(path_en) && path_en && cfg.reg_en &&
     !cfg.neg_edge && !cfg.ddr) |-> (data_hi == $past(pad_i)));

  // R4: falling-edge capture (single or DDR low stream)
  a_r4_fall_capture: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(path_en) && path_en && cfg.reg_en &&
     (cfg.neg_edge || cfg.ddr)) |-> ((cfg.ddr ? data_lo : data_hi) == $past(pad_i)));

endmodule

// File: rtl/pin_out_path.sv
`timescale 1ns/1ps
module pin_out_path
  import pin_io_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      path_en,
  input  path_cfg_t cfg,
  input  logic      invert,
  input  logic      d_hi,
  input  logic      d_lo,
  input  logic      oe_i,
  output logic      q,
  output logic      oe_q
);

  logic p_hi, p_hi_d;
  logic p_lo, p_lo_d;
  logic n_q,  n_d;
  logic oe_p, oe_p_d;
  logic oe_n, oe_n_d;
  logic sel_v;

  always_comb begin
    p_hi_d = path_en ? d_hi : p_hi;
    p_lo_d = path_en ? d_lo : p_lo;
    oe_p_d = path_en ? oe_i : oe_p;
    oe_n_d = path_en ? oe_i : oe_n;
    n_d    = path_en ? (cfg.ddr ? p_lo : d_hi) : n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hi <= 1'b0;
      p_lo <= 1'b0;
      oe_p <= 1'b0;
    end else begin
      p_hi <= p_hi_d;
      p_lo <= p_lo_d;
      oe_p <= oe_p_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q  <= 1'b0;
      oe_n <= 1'b0;
    end else begin
      n_q  <= n_d;
      oe_n <= oe_n_d;
    end
  end

  // clock-level select: high phase shows rising data, low phase the retimed low bit
  always_comb begin
    if (!cfg.reg_en) begin
      sel_v = d_hi;
      oe_q  = oe_i;
    end else if (cfg.ddr) begin
      sel_v = clk ? p_hi : n_q;
      oe_q  = oe_p;
    end else if (cfg.neg_edge) begin
      sel_v = n_q;
      oe_q  = oe_n;
    end else begin
      sel_v = p_hi;
      oe_q  = oe_p;
    end
    q = sel_v ^ invert;
  end

  // R7: rising launch register takes the core bit of the previous edge
  a_r7_launch_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(path_en) && path_en && cfg.reg_en && !cfg.neg_edge)
    |-> (p_hi == $past(d_hi)));

  // R8: low-phase DDR bit is the one captured at the preceding rising edge
  a_r8_low_phase: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(path_en) && path_en && cfg.reg_en && cfg.ddr)
    |-> (n_q == $past(p_lo)));

  // R10: registered enable follows the core enable
  a_r10_oe_track: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(path_en) && path_en && cfg.reg_en && !cfg.neg_edge)
    |-> (oe_p == $past(oe_i)));

endmodule

// File: rtl/pin_io_cell.sv
`timescale 1ns/1ps
module pin_io_cell
  import pin_io_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_in,
  input  logic             clk_out,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_in_reg,
  input  logic             cfg_in_neg,
  input  logic             cfg_in_ddr,
  input  logic             cfg_out_reg,
  input  logic             cfg_out_neg,
  input  logic             cfg_out_ddr,
  input  logic             cfg_out_inv,
  input  logic             cfg_pull_dn,
  input  logic [LANES-1:0] core_out_hi,
  input  logic [LANES-1:0] core_out_lo,
  input  logic [LANES-1:0] core_oe,
  input  logic [LANES-1:0] pad_in,
  output logic [LANES-1:0] core_in_hi,
  output logic [LANES-1:0] core_in_lo,
  output logic [LANES-1:0] core_alt,
  output logic [LANES-1:0] pad_out,
  output logic [LANES-1:0] pad_oe,
  output logic             pad_pull_en,
  output logic             pad_pull_up
);

  pin_mode_e         mode;
  logic              in_en;
  logic              out_en;
  logic              rst_in_s;
  logic              rst_out_s;
  path_cfg_t         in_cfg;
  path_cfg_t         out_cfg;
  logic [LANES-1:0]  lane_q;
  logic [LANES-1:0]  lane_oe;

  assign mode    = pin_mode_e'(cfg_mode);
  assign in_en   = (mode == PM_IN)  || (mode == PM_BIDIR);
  assign out_en  = (mode == PM_OUT) || (mode == PM_BIDIR);
  assign in_cfg  = '{reg_en: cfg_in_reg,  neg_edge: cfg_in_neg,  ddr: cfg_in_ddr};
  assign out_cfg = '{reg_en: cfg_out_reg, neg_edge: cfg_out_neg, ddr: cfg_out_ddr};

  pin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_in (
    .clk(clk_in), .arst_n(rst_n), .rst_n_sync(rst_in_s));

  pin_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_out (
    .clk(clk_out), .arst_n(rst_n), .rst_n_sync(rst_out_s));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pin_in_path u_in (
      .clk     (clk_in),
      .rst_n   (rst_in_s),
      .path_en (in_en),
      .cfg     (in_cfg),
      .pad_i   (pad_in[g]),
      .data_hi (core_in_hi[g]),
      .data_lo (core_in_lo[g]),
      .alt     (core_alt[g])
    );

    pin_out_path u_out (
      .clk     (clk_out),
      .rst_n   (rst_out_s),
      .path_en (out_en),
      .cfg     (out_cfg),
      .invert  (cfg_out_inv),
      .d_hi    (core_out_hi[g]),
      .d_lo    (core_out_lo[g]),
      .oe_i    (core_oe[g]),
      .q       (lane_q[g]),
      .oe_q    (lane_oe[g])
    );
  end

  always_comb begin
    pad_oe      = '0;
    pad_out     = '0;
    pad_pull_en = 1'b0;
    case (mode)
      PM_IN: ;
      PM_OUT: begin
        pad_oe  = '1;
        pad_out = lane_q;
      end
      PM_BIDIR: begin
        pad_oe  = lane_oe;
        pad_out = lane_q & lane_oe;
      end
      PM_CLKOUT: begin
        pad_oe  = '1;
        pad_out = {LANES{clk_out}};
      end
      default: pad_pull_en = 1'b1;
    endcase
    pad_pull_up = pad_pull_en & ~cfg_pull_dn;
  end

  // R1: an unused pin neither drives nor delivers data to the core
  a_r1_idle_quiet: assert property (@(posedge clk_in) disable iff (!rst_in_s)
    (!in_en && !out_en && mode != PM_CLKOUT)
    |-> (pad_oe == '0 && core_in_hi == '0 && core_alt == '0));

endmodule

// File: tb/pin_io_cell_test.sv
`timescale 1ns/1ps
module pin_io_cell_test;

  localparam int LANES = 4;

  logic             clk_in = 1'b0;
  logic             clk_out = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cfg_mode = 3'd0;
  logic             cfg_in_reg = 0, cfg_in_neg = 0, cfg_in_ddr = 0;
  logic             cfg_out_reg = 0, cfg_out_neg = 0, cfg_out_ddr = 0;
  logic             cfg_out_inv = 0, cfg_pull_dn = 0;
  logic [LANES-1:0] core_out_hi = '0, core_out_lo = '0, core_oe = '0, pad_in = '0;
  logic [LANES-1:0] core_in_hi, core_in_lo, core_alt, pad_out, pad_oe;
  logic             pad_pull_en, pad_pull_up;

  int checks = 0;
  int failures = 0;
  int since_release = 0;

  pin_io_cell #(.LANES(LANES)) uut (
    .clk_in(clk_in), .clk_out(clk_out), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_in_reg(cfg_in_reg), .cfg_in_neg(cfg_in_neg), .cfg_in_ddr(cfg_in_ddr),
    .cfg_out_reg(cfg_out_reg), .cfg_out_neg(cfg_out_neg), .cfg_out_ddr(cfg_out_ddr),
    .cfg_out_inv(cfg_out_inv), .cfg_pull_dn(cfg_pull_dn),
    .core_out_hi(core_out_hi), .core_out_lo(core_out_lo), .core_oe(core_oe),
    .pad_in(pad_in), .core_in_hi(core_in_hi), .core_in_lo(core_in_lo),
    .core_alt(core_alt), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up));

  // 50 MHz on both clocks, output clock offset by a quarter period
  always #10 clk_in = ~clk_in;
  initial begin
    #5;
    forever #10 clk_out = ~clk_out;
  end

  // ---------------- behavioural reference state ----------------
  logic [LANES-1:0] m_in_rise = '0, m_in_fall = '0;
  logic [LANES-1:0] m_hi = '0, m_lo = '0, m_low_phase = '0, m_oe_r = '0, m_oe_f = '0;
  int cnt_in = 0, cnt_out = 0;

  function automatic bit in_on();
    return cfg_mode == 3'd1 || cfg_mode == 3'd3;
  endfunction
  function automatic bit out_on();
    return cfg_mode == 3'd2 || cfg_mode == 3'd3;
  endfunction

  always @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt_in = 0; m_in_rise = '0; m_in_fall = '0;
    end else begin
      if (cnt_in >= 2 && in_on()) m_in_rise = pad_in;
      if (cnt_in < 2) cnt_in++;
    end
  end
  always @(negedge clk_in) begin
    if (rst_n && cnt_in >= 2 && in_on()) m_in_fall = pad_in;
  end
  always @(posedge clk_out or negedge rst_n) begin
    if (!rst_n) begin
      cnt_out = 0; m_hi = '0; m_lo = '0; m_low_phase = '0; m_oe_r = '0; m_oe_f = '0;
    end else begin
      if (cnt_out >= 2 && out_on()) begin
        m_hi = core_out_hi; m_lo = core_out_lo; m_oe_r = core_oe;
      end
      if (cnt_out < 2) cnt_out++;
    end
  end
  always @(negedge clk_out) begin
    if (rst_n && cnt_out >= 2 && out_on()) begin
      m_low_phase = cfg_out_ddr ? m_lo : core_out_hi;
      m_oe_f = core_oe;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what,
                     input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [LANES-1:0] e_hi, e_lo, e_alt, e_v, e_oe, e_pout, e_poe;
    logic e_pen, e_pup;
    string t_in, t_out, t_oe;
    bit early;
    early = !rst_n || since_release < 6;
    e_hi = '0; e_lo = '0; e_alt = '0;
    if (in_on()) begin
      e_alt = pad_in;
      if (!cfg_in_reg) e_hi = pad_in;
      else if (cfg_in_ddr) begin e_hi = m_in_rise; e_lo = m_in_fall; end
      else e_hi = cfg_in_neg ? m_in_fall : m_in_rise;
    end
    if (!cfg_out_reg)     begin e_v = core_out_hi; e_oe = core_oe; end
    else if (cfg_out_ddr) begin e_v = clk_out ? m_hi : m_low_phase; e_oe = m_oe_r; end
    else if (cfg_out_neg) begin e_v = m_low_phase; e_oe = m_oe_f; end
    else                  begin e_v = m_hi; e_oe = m_oe_r; end
    e_v = e_v ^ {LANES{cfg_out_inv}};
    e_pen = 0; e_pout = '0; e_poe = '0;
    case (cfg_mode)
      3'd1: ;
      3'd2: begin e_poe = '1; e_pout = e_v; end
      3'd3: begin e_poe = e_oe; e_pout = e_v & e_oe; end
      3'd4: begin e_poe = '1; e_pout = {LANES{clk_out}}; end
      default: e_pen = 1;
    endcase
    e_pup = e_pen & !cfg_pull_dn;

    if (!in_on()) t_in = "R1";
    else if (!cfg_in_reg) t_in = "R2";
    else if (cfg_in_ddr) t_in = "R4";
    else t_in = "R3";
    if (cfg_mode == 3'd4) t_out = "R11";
    else if (!out_on()) t_out = "R1";
    else if (cfg_out_inv) t_out = "R9";
    else if (!cfg_out_reg) t_out = "R6";
    else if (cfg_out_ddr) t_out = "R8";
    else t_out = "R7";
    t_oe = (cfg_mode == 3'd3) ? "R10" : t_out;
    if (early) begin t_in = "R12"; t_out = "R12"; t_oe = "R12"; end

    chk(t_in, "core_in_hi", core_in_hi, e_hi);
    chk(in_on() ? "R4" : "R1", "core_in_lo", core_in_lo, e_lo);
    chk(in_on() ? "R5" : "R1", "core_alt", core_alt, e_alt);
    chk(t_out, "pad_out", pad_out, e_pout);
    chk(t_oe, "pad_oe", pad_oe, e_poe);
    chk("R1", "pull", {{(LANES-2){1'b0}}, pad_pull_en, pad_pull_up}, {{(LANES-2){1'b0}}, e_pen, e_pup});
  endtask

  // one tick: drive at +2 ns, compare at +8 ns (clk_out edge at +5, clk_in edge at +10)
  task automatic tick();
    core_out_hi = LANES'($urandom);
    core_out_lo = LANES'($urandom);
    core_oe     = LANES'($urandom);
    pad_in      = LANES'($urandom);
    #6;
    compare();
    #4;
    if (rst_n) since_release++;
  endtask

  task automatic run_cfg(input logic [2:0] md, input bit ir, input bit ineg, input bit iddr,
                         input bit oreg, input bit oneg, input bit oddr,
                         input bit inv, input bit pdn);
    rst_n = 1'b0;
    since_release = 0;
    cfg_mode = md; cfg_in_reg = ir; cfg_in_neg = ineg; cfg_in_ddr = iddr;
    cfg_out_reg = oreg; cfg_out_neg = oneg; cfg_out_ddr = oddr;
    cfg_out_inv = inv; cfg_pull_dn = pdn;
    for (int i = 0; i < 3; i++) tick();   // R12: outputs during reset
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) tick();
  endtask

  initial begin
    #2;
    run_cfg(3'd0, 0,0,0, 0,0,0, 0,0);   // R1 off, pull-up
    run_cfg(3'd0, 1,0,0, 1,0,0, 1,1);   // R1 off, pull-down
    run_cfg(3'd6, 0,0,0, 0,0,0, 0,0);   // R1 undefined code
    run_cfg(3'd1, 0,0,0, 0,0,0, 0,0);   // R2 R5 direct input
    run_cfg(3'd1, 1,0,0, 0,0,0, 0,0);   // R3 rising
    run_cfg(3'd1, 1,1,0, 0,0,0, 0,1);   // R3 falling
    run_cfg(3'd1, 1,1,1, 0,0,0, 0,0);   // R4 DDR capture
    run_cfg(3'd2, 0,0,0, 0,0,0, 0,0);   // R6 direct output
    run_cfg(3'd2, 0,0,0, 1,0,0, 0,0);   // R7 rising
    run_cfg(3'd2, 0,0,0, 1,1,0, 1,0);   // R7 falling, R9 inverted
    run_cfg(3'd2, 0,0,0, 1,0,1, 0,0);   // R8 DDR launch
    run_cfg(3'd2, 0,0,0, 1,1,1, 1,0);   // R8 R9 DDR inverted
    run_cfg(3'd2, 0,0,0, 0,0,0, 1,0);   // R9 direct inverted
    run_cfg(3'd3, 0,0,0, 0,0,0, 0,0);   // R10 direct bidirectional
    run_cfg(3'd3, 1,0,0, 1,1,0, 0,0);   // R10 registered, falling output
    run_cfg(3'd3, 1,0,1, 1,0,1, 1,0);   // R10 DDR both ways
    run_cfg(3'd4, 1,0,0, 1,0,0, 1,0);   // R11 clock forwarding
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule